// File: doc/BRIEF.md
# Shared Event Output Combiner

Several debug clients each have an active-low event request, and all of them share one active-low event pin. This block joins the requests with a wired-AND, so the pin asserts whenever any client asserts. Each new request turns into a pulse on the shared pin that lasts exactly one period of the trace clock, counted in system clock cycles.

The trace clock divide ratio can be full rate, /2, /4 or /8. When the trace clock is not running, the pulse is sized as if the trace clock ran at half the system rate. Requests are taken on their asserting (falling) edge, and each client is watched separately. A request that arrives while a pulse is on the pin is held in a single pending flag. It is then emitted as one fresh pulse after the current pulse has finished and the pin has been high for one cycle.

Generating the trace clock and the clients themselves lie outside this block. The block only needs the system clock, a synchronous reset, the request vector, a trace-active flag and the current divide code.

Top module: `evt_share_combiner`

## Requirements
- R1: While `rst` is high, and after reset until a request edge is seen, `evt_n` is high.
- R2: A falling edge on any bit of `req_n` produces a pulse, and the behaviour is the same whatever bit position the client occupies.
- R3: With `trc_active` = 1, the pulse lasts 1, 2, 4 or 8 system cycles for `trc_div` codes 0, 1, 2 and 3 respectively.
- R4: With `trc_active` = 0, the pulse lasts 2 system cycles whatever the value of `trc_div`.
- R5: A request held low for many cycles produces only one pulse.
- R6: A falling edge that arrives during a pulse does not lengthen that pulse. After the pulse ends, `evt_n` is high for exactly one cycle and then one fresh pulse of the configured width follows. Several such edges merge into that one fresh pulse.
- R7: Falling edges on several clients in the same cycle produce a single pulse.
- R8: The edge history is reset to the deasserted state, so a request that is already low when reset is released produces a pulse.
- R9: The pulse width is fixed when the pulse starts. A change of `trc_div` or `trc_active` during a pulse does not change that pulse.
- R10: When the block is idle, `evt_n` goes low on the first clock edge at which a falling request edge is present, that is, one edge after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | N_CLIENTS | Active-low event requests, one bit per client |
| trc_active | input | 1 | 1 when the trace clock is running |
| trc_div | input | 2 | Trace divide code: 0 full, 1 /2, 2 /4, 3 /8 |
| evt_n | output | 1 | Active-low shared event pin |

## Verification
A request change driven between clock edges shows up on `evt_n` at the next rising edge. The bench therefore drives on a falling edge and expects the first low sample at the following falling edge. It then counts consecutive low samples at falling edges and compares the count with the width computed from the divide code and the active flag. For a pending request, the bench expects exactly one high sample right after the first pulse, followed by a second pulse of the full configured width. Quiet windows after each pulse, with the request still held low, confirm that no further pulse appears.

// File: rtl/evtshare_pkg.sv
package evtshare_pkg;

    typedef enum logic [1:0] {
        DIV_FULL    = 2'd0,
        DIV_HALF    = 2'd1,
        DIV_QUARTER = 2'd2,
        DIV_EIGHTH  = 2'd3
    } trc_div_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } pstate_e;

    localparam int unsigned MAX_PULSE = 8;
    localparam int unsigned CNT_W     = $clog2(MAX_PULSE);
    localparam trc_div_e    FALLBACK_DIV = DIV_HALF;

    typedef logic [CNT_W-1:0] pulse_cnt_t;

    typedef struct packed {
        logic     active;
        trc_div_e div;
    } trc_cfg_t;

    function automatic trc_div_e effective_div(trc_cfg_t cfg);
        return cfg.active ? cfg.div : FALLBACK_DIV;
    endfunction

    function automatic pulse_cnt_t pulse_last(trc_div_e d);
        pulse_cnt_t r;
        case (d)
            DIV_FULL:    r = pulse_cnt_t'(0);
            DIV_HALF:    r = pulse_cnt_t'(1);
            DIV_QUARTER: r = pulse_cnt_t'(3);
            default:     r = pulse_cnt_t'(7);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/evtshare_edge.sv
module evtshare_edge #(
    parameter int unsigned N_CLIENTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CLIENTS-1:0] req_n,
    output logic                 fall_any
);
    logic [N_CLIENTS-1:0] hist_n;
    logic [N_CLIENTS-1:0] fall_v;

    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_client
        always_ff @(posedge clk) begin
            if (rst) hist_n[i] <= 1'b1;
            else     hist_n[i] <= req_n[i];
        end

        assign fall_v[i] = hist_n[i] & ~req_n[i];

        // R5: a request already low on the previous cycle raises no edge
        a_r5_held_no_edge: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(req_n[i]) && !req_n[i]) |-> !fall_v[i]);
    end

    assign fall_any = |fall_v;

endmodule

// File: rtl/evtshare_timer.sv
module evtshare_timer
    import evtshare_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  pulse_cnt_t last_cnt,
    output logic       evt_n
);
    pstate_e    state;
    pulse_cnt_t cnt;
    logic       pend;
    logic       evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            pend  <= 1'b0;
            evt_q <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (trig || pend) begin
                        state <= ST_PULSE;
                        cnt   <= last_cnt;
                        evt_q <= 1'b0;
                        pend  <= 1'b0;
                    end
                end
                default: begin
                    pend <= pend | trig;
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        evt_q <= 1'b1;
                    end else begin
                        cnt <= cnt - pulse_cnt_t'(1);
                    end
                end
            endcase
        end
    end

    assign evt_n = evt_q;

    logic [CNT_W:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)             low_run <= '0;
        else if (evt_q)      low_run <= '0;
        else if (low_run != '1) low_run <= low_run + 1'b1;
    end

    // R3: no pulse is longer than the widest configurable period
    a_r3_max_width: assert property (@(posedge clk) disable iff (rst)
        low_run <= (CNT_W+1)'(MAX_PULSE));

    // R6: the last pulse cycle always releases the pin, even with a new request
    a_r6_no_extend: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE && cnt == '0) |=> evt_q);

    // R10: an idle timer starts on the edge where a trigger is present
    a_r10_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && trig) |=> !evt_q);

endmodule

// File: rtl/evt_share_combiner.sv
module evt_share_combiner
    import evtshare_pkg::*;
#(
    parameter int unsigned N_CLIENTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CLIENTS-1:0] req_n,
    input  logic                 trc_active,
    input  logic [1:0]           trc_div,
    output logic                 evt_n
);
    trc_cfg_t   cfg;
    pulse_cnt_t last_cnt;
    logic       fall_any;

    always_comb begin
        cfg.active = trc_active;
        cfg.div    = trc_div_e'(trc_div);
        last_cnt   = pulse_last(effective_div(cfg));
    end

    evtshare_edge #(.N_CLIENTS(N_CLIENTS)) edge_i (
        .clk      (clk),
        .rst      (rst),
        .req_n    (req_n),
        .fall_any (fall_any)
    );

    evtshare_timer timer_i (
        .clk      (clk),
        .rst      (rst),
        .trig     (fall_any),
        .last_cnt (last_cnt),
        .evt_n    (evt_n)
    );

    // R1: the pin comes out of reset deasserted
    a_r1_reset_high: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> evt_n);

    // R2: every pulse begins from a request edge seen on the previous cycle or pending
    a_r2_cause: assert property (@(posedge clk) disable iff (rst)
        ($fell(evt_n) && !$past(rst)) |-> ($past(fall_any) || !$past(evt_n, 2)));

endmodule

// File: tb/evt_share_combiner_tb_top.sv
module evt_share_combiner_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req_n;
    logic         trc_active;
    logic [1:0]   trc_div;
    logic         evt_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    evt_share_combiner #(.N_CLIENTS(N)) dut_i (
        .clk(clk), .rst(rst), .req_n(req_n),
        .trc_active(trc_active), .trc_div(trc_div), .evt_n(evt_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        while (evt_n == 1'b0 && n < 40) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int cyc, input string tag);
        int lows = 0;
        for (int k = 0; k < cyc; k++) begin
            if (evt_n == 1'b0) lows++;
            @(negedge clk);
        end
        chk(lows == 0, tag, lows, 0);
    endtask

    function automatic int exp_width(input bit act, input int d);
        return act ? (1 << d) : 2;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; req_n = '1; trc_active = 1'b1; trc_div = 2'd0;
        repeat (3) @(negedge clk);
        chk(evt_n == 1'b1, "R1 high in reset", evt_n, 1);
        rst = 1'b0;
        @(negedge clk);
        quiet(5, "R1 high after reset");

        // R2 R3 R4 R5 sweep over activity, divide code and client position
        for (int a = 0; a < 2; a++) begin
            for (int d = 0; d < 4; d++) begin
                for (int c = 0; c < N; c++) begin
                    trc_active = a[0];
                    trc_div    = d[1:0];
                    req_n[c]   = 1'b0;
                    @(negedge clk);
                    chk(evt_n == 1'b0, "R10 first low one edge after request", evt_n, 0);
                    measure(n);
                    chk(n == exp_width(a[0], d), a ? "R3 width active" : "R4 width inactive",
                        n, exp_width(a[0], d));
                    chk(n > 0, "R2 client position", c, c);
                    quiet(6, "R5 held request single pulse");
                    req_n = '1;
                    repeat (2) @(negedge clk);
                end
            end
        end

        // R7 simultaneous requests
        trc_active = 1'b1; trc_div = 2'd2;
        req_n = '0;
        @(negedge clk);
        measure(n);
        chk(n == 4, "R7 simultaneous single pulse", n, 4);
        quiet(6, "R7 no second pulse");
        req_n = '1;
        repeat (2) @(negedge clk);

        // R6 requests during a pulse
        trc_div = 2'd3;
        req_n[0] = 1'b0;
        @(negedge clk);
        req_n[1] = 1'b0;
        @(negedge clk);
        req_n[2] = 1'b0;
        @(negedge clk);
        req_n[3] = 1'b0;
        n = 3;
        while (evt_n == 1'b0 && n < 40) begin
            @(negedge clk);
            if (evt_n == 1'b0) n++;
        end
        chk(n == 8, "R6 first pulse not extended", n, 8);
        chk(evt_n == 1'b1, "R6 one-cycle gap", evt_n, 1);
        @(negedge clk);
        measure(n);
        chk(n == 8, "R6 fresh pulse width", n, 8);
        quiet(6, "R6 merged into one pulse");
        req_n = '1;
        repeat (2) @(negedge clk);

        // R9 width fixed at start
        trc_div = 2'd3;
        req_n[1] = 1'b0;
        @(negedge clk);
        trc_div = 2'd0; trc_active = 1'b0;
        measure(n);
        chk(n == 8, "R9 width latched", n, 8);
        req_n = '1; trc_active = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset during a pulse
        trc_div = 2'd3;
        req_n[2] = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(evt_n == 1'b1, "R1 reset ends pulse", evt_n, 1);

        // R8 request low across reset release
        req_n = '1; req_n[3] = 1'b0; trc_div = 2'd1;
        repeat (2) @(negedge clk);
        chk(evt_n == 1'b1, "R1 high while reset with request", evt_n, 1);
        rst = 1'b0;
        @(negedge clk);
        measure(n);
        chk(n == 2, "R8 pulse after reset release", n, 2);
        quiet(4, "R8 single pulse");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule